// File: doc/BRIEF.md
# Multi-cycle accumulator CPU sequencer

This block is a small processor core that runs one instruction at a time through a fetch, decode and execute state machine. Every clock performs a single register transfer between a program counter, a memory address register, a memory buffer register, an instruction register, an accumulator and a four-bit condition register. Memory is reached through one synchronous port. Only the address register drives the address, only the buffer register supplies write data, and only the buffer register captures read data.

The instruction set has four operations: load, store, add and an unconditional jump. There is also a halt and a family of no-op codes. Load and add take either an immediate operand, which is a literal inside the instruction, or a direct operand, which is an address that costs one extra memory read. The program counter is advanced inside fetch, so a jump replaces a value that has already been incremented.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter, accumulator and flags are cleared to zero and the sequencer returns to its first fetch step. No read or write strobe is asserted during reset.
- R2: Fetch runs on successive clocks in this order: PC into MAR, a read strobe with mem_addr equal to PC, capture of read data into MBR, MBR into the instruction register, then PC+1. PC already holds the incremented value in the decode step.
- R3: Instruction word fields: bits 15:12 are the opcode, bit 11 is the mode (1 = immediate, 0 = direct) and bits 10:0 are the operand. Opcodes are 0001 load, 0010 store, 0011 add, 0100 jump and 1111 halt.
- R4: An immediate operand is the operand field zero-extended to 16 bits and causes no memory read. An immediate load or add takes 7 clocks.
- R5: A direct operand causes exactly one extra read at the operand address, and its data comes from MBR. A direct load or add takes 10 clocks.
- R6: Add writes accumulator plus operand data back to the accumulator and sets flags_out = {Z, C, V, N} (bit 3 zero, bit 2 carry out, bit 1 signed overflow, bit 0 sign of the result).
- R7: Only add changes the flags. Load, store, jump, halt and no-op leave them unchanged.
- R8: A direct store puts the operand address on mem_addr and the accumulator on mem_wdata and asserts mem_wr for exactly one clock. It takes 8 clocks.
- R9: A store with the mode bit set to immediate writes nothing and behaves as a no-op of 6 clocks.
- R10: A jump loads PC with the operand field whatever the mode bit, so the next fetch comes from the target. It takes 7 clocks.
- R11: Any opcode not listed in R3 is a no-op of 6 clocks. It changes neither the accumulator nor the flags.
- R12: Halt raises halted after 6 clocks. The sequencer then stays idle with no strobes until reset.
- R13: mem_rd and mem_wr are never asserted in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 11 | Memory address, driven by MAR |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one clock later |
| mem_wr | output | 1 | Write strobe, one clock per store |
| mem_wdata | output | 16 | Write data, driven by MBR |
| mem_rdata | input | 16 | Read data from memory |
| acc_out | output | 16 | Accumulator value |
| flags_out | output | 4 | Condition flags {Z, C, V, N} |
| pc_out | output | 11 | Program counter |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench runs a program that places a jump straight after a no-op and an ignored immediate store. A design that incremented PC after execute, or that honoured the store, would fetch the wrong target, write an extra word, or miss the total cycle count. A load between two flag-checked stores catches a design that lets load disturb the flags. An add of 0x8000 to 0x8000 must set carry, overflow and zero together, and 0x7FFF plus 5 must set overflow without carry, which catches a design that swaps or merges the two. The total read count and the clock count to halt separate immediate from direct operand handling: a design that read memory for immediate operands, or skipped the operand read for direct ones, would miss both totals. The bench also checks that nothing moves after halt.

// File: rtl/acc_cpu_pkg.sv
// Package acc_cpu_pkg
// Shared opcodes, sequencer states, condition flags and the control word.
// Assumes a 4-bit opcode field; the core widths are parameters of the modules.
package acc_cpu_pkg;

    localparam logic [3:0] OP_LOAD  = 4'b0001;
    localparam logic [3:0] OP_STORE = 4'b0010;
    localparam logic [3:0] OP_ADD   = 4'b0011;
    localparam logic [3:0] OP_JMP   = 4'b0100;
    localparam logic [3:0] OP_HALT  = 4'b1111;

    // One state per register transfer.
    typedef enum logic [3:0] {
        S_F_ADDR   = 4'd0,   // PC -> MAR
        S_F_READ   = 4'd1,   // read strobe at MAR
        S_F_LATCH  = 4'd2,   // read data -> MBR
        S_F_CIR    = 4'd3,   // MBR -> instruction register
        S_F_INC    = 4'd4,   // PC + 1
        S_DECODE   = 4'd5,   // opcode and mode select the path
        S_O_ADDR   = 4'd6,   // operand address -> MAR
        S_O_READ   = 4'd7,   // read strobe at MAR
        S_O_LATCH  = 4'd8,   // read data -> MBR
        S_EXEC     = 4'd9,   // accumulator or PC update
        S_ST_SETUP = 4'd10,  // operand -> MAR, accumulator -> MBR
        S_ST_WRITE = 4'd11,  // write strobe
        S_HALT     = 4'd12   // parked until reset
    } seq_state_t;

    // Condition flags; zero is the MSB so the packed value reads {Z,C,V,N}.
    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
        logic neg;
    } cond_t;

    // Control word from the sequencer to the datapath.
    typedef struct packed {
        logic mar_pc;
        logic mar_opr;
        logic mbr_mem;
        logic mbr_acc;
        logic cir_ld;
        logic pc_inc;
        logic pc_jmp;
        logic acc_ld;
        logic acc_add;
        logic mem_rd;
        logic mem_wr;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Module acc_cpu_alu
// Combinational adder that produces the sum and the four condition flags.
// Assumes two's complement operands of DATA_W bits.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] sum_out,
    output cond_t             cond_out
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide_sum;

    // Add with one extra bit to keep the carry out.
    always_comb begin
        wide_sum = {1'b0, a_in} + {1'b0, b_in};
    end

    // Derive the result and the flags from the wide sum.
    always_comb begin
        sum_out        = wide_sum[MSB:0];
        cond_out.zero  = (wide_sum[MSB:0] == '0);
        cond_out.carry = wide_sum[DATA_W];
        cond_out.ovf   = (a_in[MSB] == b_in[MSB]) && (wide_sum[MSB] != a_in[MSB]);
        cond_out.neg   = wide_sum[MSB];
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module acc_cpu_ctrl
// Fetch, decode and execute sequencer. It issues one register transfer per
// clock through the control word. Assumes the opcode and mode bit come from
// the instruction register and stay stable from decode until execute ends.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             imm_mode,
    output ctl_t             ctl,
    output logic             halted
);

    seq_state_t state;
    seq_state_t state_nxt;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_F_ADDR;
        else        state <= state_nxt;
    end

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        case (state)
            S_F_ADDR:   state_nxt = S_F_READ;
            S_F_READ:   state_nxt = S_F_LATCH;
            S_F_LATCH:  state_nxt = S_F_CIR;
            S_F_CIR:    state_nxt = S_F_INC;
            S_F_INC:    state_nxt = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_ADD: state_nxt = imm_mode ? S_EXEC : S_O_ADDR;
                    OP_STORE:        state_nxt = imm_mode ? S_F_ADDR : S_ST_SETUP;
                    OP_JMP:          state_nxt = S_EXEC;
                    OP_HALT:         state_nxt = S_HALT;
                    default:         state_nxt = S_F_ADDR;
                endcase
            end
            S_O_ADDR:   state_nxt = S_O_READ;
            S_O_READ:   state_nxt = S_O_LATCH;
            S_O_LATCH:  state_nxt = S_EXEC;
            S_EXEC:     state_nxt = S_F_ADDR;
            S_ST_SETUP: state_nxt = S_ST_WRITE;
            S_ST_WRITE: state_nxt = S_F_ADDR;
            S_HALT:     state_nxt = S_HALT;
            default:    state_nxt = S_F_ADDR;
        endcase
    end

    // Control word for the current state.
    always_comb begin
        ctl = '0;
        case (state)
            S_F_ADDR:   ctl.mar_pc  = 1'b1;
            S_F_READ:   ctl.mem_rd  = 1'b1;
            S_F_LATCH:  ctl.mbr_mem = 1'b1;
            S_F_CIR:    ctl.cir_ld  = 1'b1;
            S_F_INC:    ctl.pc_inc  = 1'b1;
            S_O_ADDR:   ctl.mar_opr = 1'b1;
            S_O_READ:   ctl.mem_rd  = 1'b1;
            S_O_LATCH:  ctl.mbr_mem = 1'b1;
            S_EXEC: begin
                case (opcode)
                    OP_LOAD: ctl.acc_ld  = 1'b1;
                    OP_ADD:  ctl.acc_add = 1'b1;
                    OP_JMP:  ctl.pc_jmp  = 1'b1;
                    default: ctl = '0;
                endcase
            end
            S_ST_SETUP: begin
                ctl.mar_opr = 1'b1;
                ctl.mbr_acc = 1'b1;
            end
            S_ST_WRITE: ctl.mem_wr  = 1'b1;
            default:    ctl = '0;
        endcase
    end

    // Idle indication once a halt has been decoded.
    always_comb begin
        halted = (state == S_HALT);
    end

    // R12: a parked sequencer stays parked.
    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |=> (state == S_HALT));

    // R12: no strobes while parked.
    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(ctl.mem_rd || ctl.mem_wr));

    // R8: the write strobe follows a store setup step by one clock.
    assert_store_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_wr |-> $past(ctl.mar_opr && ctl.mbr_acc));

    // R5: an operand read follows loading MAR with the operand.
    assert_opr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_O_READ) |-> $past(ctl.mar_opr));

endmodule

// File: rtl/acc_cpu_dp.sv
// Module acc_cpu_dp
// Register file of the core: PC, MAR, MBR, instruction register,
// accumulator and flags, each loaded by its own enable from the control word.
// Assumes memory read data is valid in the clock after the read strobe.
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 11,
    localparam int DATA_W = OPC_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opcode,
    output logic              imm_mode,
    output logic [DATA_W-1:0] acc_out,
    output cond_t             cond_out,
    output logic [ADDR_W-1:0] pc_out
);

    localparam int EXT_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] cir;
    logic [DATA_W-1:0] acc;
    cond_t             flags;

    logic [ADDR_W-1:0] opr;
    logic [DATA_W-1:0] opr_data;
    logic [DATA_W-1:0] sum;
    cond_t             sum_cond;

    // Split the instruction register into its fields.
    always_comb begin
        opcode   = cir[DATA_W-1 -: OPC_W];
        imm_mode = cir[ADDR_W];
        opr      = cir[ADDR_W-1:0];
    end

    // The operand is the zero-extended field or the buffer register.
    always_comb begin
        opr_data = imm_mode ? {{EXT_W{1'b0}}, opr} : mbr;
    end

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a_in     (acc),
        .b_in     (opr_data),
        .sum_out  (sum),
        .cond_out (sum_cond)
    );

    // Program counter: increment in fetch, overwrite on a jump.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctl.pc_inc) pc <= pc + 1'b1;
        else if (ctl.pc_jmp) pc <= opr;
    end

    // Memory address register: from PC in fetch, from the operand otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           mar <= '0;
        else if (ctl.mar_pc)  mar <= pc;
        else if (ctl.mar_opr) mar <= opr;
    end

    // Memory buffer register: from read data or from the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)           mbr <= '0;
        else if (ctl.mbr_mem) mbr <= mem_rdata;
        else if (ctl.mbr_acc) mbr <= acc;
    end

    // Instruction register: loaded from MBR in fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)          cir <= '0;
        else if (ctl.cir_ld) cir <= mbr;
    end

    // Accumulator: load copies the operand, add writes the sum.
    always_ff @(posedge clk) begin
        if (!rst_n)           acc <= '0;
        else if (ctl.acc_ld)  acc <= opr_data;
        else if (ctl.acc_add) acc <= sum;
    end

    // Flags: only an add updates them.
    always_ff @(posedge clk) begin
        if (!rst_n)           flags <= '0;
        else if (ctl.acc_add) flags <= sum_cond;
    end

    // Memory and observation outputs come straight from registers.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        acc_out   = acc;
        cond_out  = flags;
        pc_out    = pc;
    end

    // R2: the increment step adds exactly one.
    assert_pc_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> (pc == $past(pc) + 1'b1));

    // R2: PC moves only in the increment step or on a jump.
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.pc_inc || ctl.pc_jmp) |=> $stable(pc));

    // R2: an instruction read addresses the PC that was copied into MAR.
    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mem_rd && $past(ctl.mar_pc)) |-> (mem_addr == $past(pc)));

    // R5: an operand read addresses the operand field.
    assert_opr_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mem_rd && $past(ctl.mar_opr)) |-> (mem_addr == opr));

    // R7: flags hold unless an add executed.
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.acc_add |=> $stable(flags));

    // R8: a write presents the accumulator at the operand address.
    assert_store_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_wr |-> (mem_wdata == acc && mem_addr == opr));

    // R13: one strobe at a time.
    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_rd && ctl.mem_wr));

endmodule

// File: rtl/acc_cpu.sv
// Module acc_cpu
// Top of the multi-cycle accumulator core: sequencer plus datapath.
// Assumes a single-port synchronous memory whose read data follows the read
// strobe by one clock. The instruction word is OPC_W + 1 + ADDR_W bits wide.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 11,
    localparam int DATA_W = OPC_W + 1 + ADDR_W,
    localparam int COND_W = $bits(cond_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out,
    output logic [COND_W-1:0] flags_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              halted
);

    ctl_t             ctl;
    logic [OPC_W-1:0] opcode;
    logic             imm_mode;
    cond_t            cond;

    acc_cpu_ctrl #(
        .OPC_W (OPC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .imm_mode (imm_mode),
        .ctl      (ctl),
        .halted   (halted)
    );

    acc_cpu_dp #(
        .OPC_W  (OPC_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .imm_mode  (imm_mode),
        .acc_out   (acc_out),
        .cond_out  (cond),
        .pc_out    (pc_out)
    );

    // Strobes and flags reach the ports without extra logic.
    always_comb begin
        mem_rd    = ctl.mem_rd;
        mem_wr    = ctl.mem_wr;
        flags_out = cond;
    end

    // R1: no strobe while reset is held.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !(mem_rd || mem_wr));

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
// Bench for acc_cpu. A driver task queues the writes a program must produce;
// a monitor pops and compares them as the core stores.
module sim_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] acc_out;
    logic [3:0]  flags_out;
    logic [10:0] pc_out;
    logic        halted;

    int checks = 0;
    int errors = 0;
    int reads_n = 0;
    int writes_n = 0;
    int edge_cnt = 0;
    int halt_at = 0;

    logic [15:0] mem [0:2047];

    typedef struct {
        logic [10:0] a;
        logic [15:0] d;
        logic [3:0]  f;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    acc_cpu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out),
        .flags_out (flags_out),
        .pc_out    (pc_out),
        .halted    (halted)
    );

    // Behavioural memory: registered read, synchronous write.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    // Count edges since reset release.
    always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: queue one expected write {address, data, flags}.
    task automatic push_wr(input logic [10:0] a, input logic [15:0] d, input logic [3:0] f);
        wr_item_t it;
        it.a = a; it.d = d; it.f = f;
        exp_q.push_back(it);
    endtask

    // R3: {opcode[15:12], mode[11] (1 = immediate), operand[10:0]}
    function automatic logic [15:0] enc(input logic [3:0] op, input logic im, input logic [10:0] a);
        return {op, im, a};
    endfunction

    // Monitor: count strobes, compare writes against the queue, note halt.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) reads_n++;
            if (mem_wr) begin
                writes_n++;
                if (exp_q.size() == 0) begin
                    chk("R9 unexpected write addr", {21'd0, mem_addr}, 32'h0);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    chk("R8 store address", {21'd0, mem_addr}, {21'd0, it.a});
                    chk("R8 store data", {16'd0, mem_wdata}, {16'd0, it.d});
                    chk("R6/R7 flags at store", {28'd0, flags_out}, {28'd0, it.f});
                end
            end
            if (halted && halt_at == 0) halt_at = edge_cnt;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 16'hDEAD;
        mem[11'h100] = 16'h7FFF;
        mem[11'h101] = 16'h0001;
        mem[11'h102] = 16'hFFFF;
        mem[11'h103] = 16'h8000;

        mem[0]  = enc(4'b0001, 1'b1, 11'd5);        // load #5
        mem[1]  = enc(4'b0010, 1'b0, 11'h200);      // store
        mem[2]  = enc(4'b0011, 1'b0, 11'h100);      // add [0x100] -> 0x8004
        mem[3]  = enc(4'b0010, 1'b0, 11'h201);      // store
        mem[4]  = enc(4'b0001, 1'b0, 11'h102);      // load [0x102]
        mem[5]  = enc(4'b0010, 1'b0, 11'h206);      // store, flags must be unchanged
        mem[6]  = enc(4'b0011, 1'b1, 11'd1);        // add #1 -> 0
        mem[7]  = enc(4'b0010, 1'b0, 11'h202);      // store
        mem[8]  = enc(4'b0010, 1'b1, 11'h203);      // store immediate: ignored (R9)
        mem[9]  = enc(4'b0101, 1'b1, 11'h0AB);      // unlisted opcode: no-op (R11)
        mem[10] = enc(4'b0100, 1'b0, 11'h020);      // jump 0x20 (R10)
        mem[11] = enc(4'b0001, 1'b1, 11'h123);      // skipped
        mem[11'h20] = enc(4'b0011, 1'b1, 11'h7FF);  // add #0x7FF
        mem[11'h21] = enc(4'b0010, 1'b0, 11'h204);  // store
        mem[11'h22] = enc(4'b0001, 1'b0, 11'h103);  // load [0x103]
        mem[11'h23] = enc(4'b0011, 1'b0, 11'h103);  // add [0x103] -> 0, C V Z
        mem[11'h24] = enc(4'b0010, 1'b0, 11'h205);  // store
        mem[11'h25] = enc(4'b1111, 1'b0, 11'h000);  // halt
        mem[11'h26] = enc(4'b0010, 1'b0, 11'h207);  // never reached

        // Expected writes, flags as {Z,C,V,N}.
        push_wr(11'h200, 16'h0005, 4'b0000);
        push_wr(11'h201, 16'h8004, 4'b0011);
        push_wr(11'h206, 16'hFFFF, 4'b0011);   // R7: load kept the flags
        push_wr(11'h202, 16'h0000, 4'b1100);
        push_wr(11'h204, 16'h07FF, 4'b0000);
        push_wr(11'h205, 16'h0000, 4'b1110);

        // Reset state.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 acc after reset", {16'd0, acc_out}, 32'h0);
        chk("R1 flags after reset", {28'd0, flags_out}, 32'h0);
        chk("R1 pc after reset", {21'd0, pc_out}, 32'h0);
        chk("R1 no strobes in reset", {30'd0, mem_rd, mem_wr}, 32'h0);
        chk("R12 not halted after reset", {31'd0, halted}, 32'h0);

        @(posedge clk); #1 rst_n = 1'b1;

        // Fetch order: read strobe at PC on the second step.
        @(posedge clk); @(negedge clk);
        chk("R2 read strobe in step 2", {31'd0, mem_rd}, 32'h1);
        chk("R2 fetch address is PC", {21'd0, mem_addr}, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 pc before increment step", {21'd0, pc_out}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R2 pc incremented before decode", {21'd0, pc_out}, 32'h1);

        // Watchdog: bounded wait for halt.
        for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: halted actual=0 expected=1");
        end else begin
            repeat (40) @(negedge clk);
            chk("R4/R5/R10/R11 clocks to halt", halt_at, 32'd134);
            chk("R12 halted stays high", {31'd0, halted}, 32'h1);
            chk("R4/R5 read count", reads_n, 32'd21);
            chk("R8/R9 write count", writes_n, 32'd6);
            chk("R8 all expected writes seen", exp_q.size(), 32'd0);
            chk("R6 final acc", {16'd0, acc_out}, 32'h0);
            chk("R6 final flags C V Z", {28'd0, flags_out}, 32'hE);
            chk("R10 pc after halt fetch", {21'd0, pc_out}, 32'h26);
            chk("R9 immediate store left memory", {16'd0, mem[11'h203]}, 32'hDEAD);
            chk("R12 no store after halt", {16'd0, mem[11'h207]}, 32'hDEAD);
            chk("R8 memory holds stored word", {16'd0, mem[11'h201]}, 32'h8004);
            chk("R13 no strobes after halt", {30'd0, mem_rd, mem_wr}, 32'h0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule